// File: doc/BRIEF.md
# Counter-Driven Operand Wakeup Scheduler

This block holds instructions that have been dispatched but not yet issued, and decides when each may issue without comparing result tags against every waiting entry. Every physical register carries a bit-vector naming the scheduler slots that wait on it. Every slot carries a small count of source operands still missing. When a register's result is announced, each slot named in its vector has its count lowered. A slot whose count reaches zero is appended to the ready queue of its issue-port class. Issue ports take work only from the heads of those queues.

Result announcements are produced inside the block. When an instruction that writes a register issues, its announcement is placed in a short delay line at the depth given by its dispatch-time delay field, which is its fixed execution latency minus one. A delay of zero announces in the issue cycle itself, so a dependent can issue in the very next cycle. A register-busy table records which registers have a producer in flight, so that dispatch counts only the sources that are still outstanding. A flush input empties the whole block in one cycle.

Top module: `dep_wakeup_sched`

## Requirements
- R1: After reset, and in the cycle after a flush, `dispReady` is 1 and both `issueValid` bits are 0.
- R2: An instruction dispatched with no outstanding source shows on `issueValid` of its class, carrying its tag, in the cycle after dispatch.
- R3: A producer with delay field d that issues in cycle t lets a consumer waiting only on its destination issue in cycle t+d+1 and not earlier; with d = 0 this is the cycle right after the producer.
- R4: A consumer with two outstanding sources written by different producers stays off every queue until both announcements have happened, and issues in the cycle after the later one.
- R5: A dispatch that names one register for both sources counts it once, so a single announcement of that register makes the instruction ready.
- R6: A source whose announcement falls in the dispatch cycle is not counted as outstanding, and the instruction issues in the next cycle.
- R7: Entries that become ready in the same cycle join their class queue in ascending slot-index order (`issueEntry` gives the slot index); entries that become ready in different cycles leave the queue in the order they became ready.
- R8: `dispClass` (0 or 1) selects the only queue an instruction can appear on; its readiness never shows on the other class.
- R9: With all 16 slots occupied `dispReady` is 0 and a dispatch attempt is ignored; a slot is freed when it issues, so `dispReady` returns to 1 in the next cycle.
- R10: A flush discards all waiting instructions, queued entries, pending announcements and busy marks: nothing it held issues afterwards, and a later instruction reading a register that was busy is ready at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empties every slot, queue, busy mark and pending announcement |
| dispValid | input | 1 | Dispatch request this cycle |
| dispReady | output | 1 | At least one slot is free |
| dispTag | input | 8 | Opaque tag returned at issue |
| dispSrc0Valid | input | 1 | First source is used |
| dispSrc0 | input | 6 | First source physical register |
| dispSrc1Valid | input | 1 | Second source is used |
| dispSrc1 | input | 6 | Second source physical register |
| dispDstValid | input | 1 | Instruction writes a register |
| dispDst | input | 6 | Destination physical register |
| dispDelay | input | 2 | Execution latency minus one (0 to 3) |
| dispClass | input | 1 | Issue-port class (0 or 1) |
| issueReq | input | 2 | Per class: port accepts the queue head this cycle |
| issueValid | output | 2 | Per class: queue head is available |
| issueEntry | output | 8 | Per class slot index of the head, class c in bits [4c+3:4c] |
| issueTag | output | 16 | Per class tag of the head, class c in bits [8c+7:8c] |

## Verification
The two functions that meet in one cycle are the dispatch-time operand check and a result announcement for the same register. The bench puts a delay-zero producer at the head of its queue and, in the cycle it is accepted, dispatches a consumer naming its destination; the consumer must appear on its queue one cycle later, whereas a design that counted the source would leave it waiting forever. A second collision, two slots waking on one announcement, is arranged so that the later-dispatched consumer sits in the lower slot, and the queue order shows whether the index rule holds.

// File: rtl/wk_pkg.sv
package wk_pkg;
  localparam int NumEntries = 16;
  localparam int NumPregs   = 64;
  localparam int NumClasses = 2;
  localparam int MaxDelay   = 3;
  localparam int TagW       = 8;
  localparam int IdxW       = $clog2(NumEntries);
  localparam int PregW      = $clog2(NumPregs);
  localparam int ClsW       = (NumClasses > 1) ? $clog2(NumClasses) : 1;
  localparam int DelayW     = $clog2(MaxDelay + 1);
  localparam int CntW       = 2;

  typedef struct packed {
    logic                  allocEn;
    logic [IdxW-1:0]       allocIdx;
    logic [NumEntries-1:0] readyMask;
  } ctrlStrobes_t;

  typedef struct packed {
    logic [CntW-1:0]                  srcCnt;
    logic [NumEntries-1:0][CntW-1:0]  decCnt;
    logic [NumEntries-1:0]            issuedMask;
  } dpStatus_t;
endpackage

// File: rtl/wk_ready_fifo.sv
module wk_ready_fifo #(
  parameter int Slots   = 16,
  parameter int Sources = 16,
  parameter int IdxW    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flush,
  input  logic [Sources-1:0] pushMask,
  input  logic               pop,
  output logic               valid,
  output logic [IdxW-1:0]    head
);
  localparam int PtrW = $clog2(Slots);

  logic [IdxW-1:0] slotQ [Slots];
  logic [PtrW-1:0] headQ, tailQ;
  logic [PtrW:0]   countQ;
  logic [PtrW:0]   pushCnt;
  logic [Slots-1:0] wrEn;
  logic [IdxW-1:0] wrData [Slots];
  logic [PtrW-1:0] pos;

  // Multi-push: lower source index lands nearer the head.
  always_comb begin
    wrEn    = '0;
    pushCnt = '0;
    pos     = '0;
    for (int s = 0; s < Slots; s++) wrData[s] = '0;
    for (int e = 0; e < Sources; e++) begin
      if (pushMask[e]) begin
        pos         = tailQ + pushCnt[PtrW-1:0];
        wrEn[pos]   = 1'b1;
        wrData[pos] = IdxW'(e);
        pushCnt     = pushCnt + 1'b1;
      end
    end
  end

  assign valid = (countQ != '0);
  assign head  = slotQ[headQ];

  always_ff @(posedge clk) begin
    for (int s = 0; s < Slots; s++)
      if (wrEn[s]) slotQ[s] <= wrData[s];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headQ  <= '0;
      tailQ  <= '0;
      countQ <= '0;
    end else if (flush) begin
      headQ  <= '0;
      tailQ  <= '0;
      countQ <= '0;
    end else begin
      headQ  <= headQ + PtrW'(pop);
      tailQ  <= tailQ + pushCnt[PtrW-1:0];
      countQ <= countQ + pushCnt - (PtrW+1)'(pop);
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN || flush)
    (int'(countQ) + int'(pushCnt) - int'(pop)) <= Slots);

  assert_pop_nonempty_R8: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> countQ != '0);
endmodule

// File: rtl/wk_datapath.sv
module wk_datapath
  import wk_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       flush,
  input  logic [TagW-1:0]            dispTag,
  input  logic                       dispSrc0Valid,
  input  logic [PregW-1:0]           dispSrc0,
  input  logic                       dispSrc1Valid,
  input  logic [PregW-1:0]           dispSrc1,
  input  logic                       dispDstValid,
  input  logic [PregW-1:0]           dispDst,
  input  logic [DelayW-1:0]          dispDelay,
  input  logic [ClsW-1:0]            dispClass,
  input  logic [NumClasses-1:0]      issueReq,
  input  ctrlStrobes_t               strobes,
  output dpStatus_t                  status,
  output logic [NumClasses-1:0]      issueValid,
  output logic [NumClasses*IdxW-1:0] issueEntry,
  output logic [NumClasses*TagW-1:0] issueTag
);
  // Entry payload
  logic [TagW-1:0]   tagQ   [NumEntries];
  logic [PregW-1:0]  dstQ   [NumEntries];
  logic [NumEntries-1:0] dstVQ;
  logic [DelayW-1:0] delayQ [NumEntries];
  logic [ClsW-1:0]   clsQ   [NumEntries];

  logic [NumPregs-1:0] busyQ, annNow, immMask;
  logic [MaxDelay-1:0][NumPregs-1:0] stageQ, stageIns;
  logic [NumPregs-1:0][NumEntries-1:0] depQ;
  logic [NumEntries-1:0] allocOH;

  logic [NumClasses-1:0] fifoValid, popEn;
  logic [NumClasses-1:0][IdxW-1:0] headIdx;
  logic [NumEntries-1:0] issuedMask;
  logic s0Out, s1Out, s1Dup;

  assign allocOH = strobes.allocEn ? (NumEntries'(1) << strobes.allocIdx) : '0;

  // Issue side
  generate
    for (genvar c = 0; c < NumClasses; c++) begin : gIssue
      assign popEn[c]      = issueReq[c] & fifoValid[c] & ~flush;
      assign issueValid[c] = fifoValid[c] & ~flush;
      assign issueEntry[c*IdxW +: IdxW] = headIdx[c];
      assign issueTag[c*TagW +: TagW]   = tagQ[headIdx[c]];
    end
  endgenerate

  always_comb begin
    issuedMask = '0;
    immMask    = '0;
    stageIns   = '0;
    for (int c = 0; c < NumClasses; c++) begin
      if (popEn[c]) begin
        issuedMask[headIdx[c]] = 1'b1;
        if (dstVQ[headIdx[c]]) begin
          if (delayQ[headIdx[c]] == '0)
            immMask[dstQ[headIdx[c]]] = 1'b1;
          else
            stageIns[delayQ[headIdx[c]] - 1'b1][dstQ[headIdx[c]]] = 1'b1;
        end
      end
    end
  end

  assign annNow = stageQ[0] | immMask;

  // Announcement delay line
  generate
    for (genvar k = 0; k < MaxDelay; k++) begin : gStage
      logic [NumPregs-1:0] fromAbove;
      if (k == MaxDelay - 1) begin : gTop
        assign fromAbove = '0;
      end else begin : gMid
        assign fromAbove = stageQ[k+1];
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)      stageQ[k] <= '0;
        else if (flush) stageQ[k] <= '0;
        else            stageQ[k] <= fromAbove | stageIns[k];
      end
    end
  endgenerate

  // Dispatch-time operand check
  assign s0Out = dispSrc0Valid & busyQ[dispSrc0] & ~annNow[dispSrc0];
  assign s1Dup = dispSrc0Valid && (dispSrc1 == dispSrc0);
  assign s1Out = dispSrc1Valid & ~s1Dup & busyQ[dispSrc1] & ~annNow[dispSrc1];
  assign status.srcCnt = {1'b0, s0Out} + {1'b0, s1Out};
  assign status.issuedMask = issuedMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      busyQ <= '0;
    else if (flush) busyQ <= '0;
    else begin
      busyQ <= (busyQ & ~annNow) |
               ((strobes.allocEn && dispDstValid) ? (NumPregs'(1) << dispDst) : '0);
    end
  end

  // Dependent sets, one row per register
  generate
    for (genvar p = 0; p < NumPregs; p++) begin : gDep
      logic joinRow;
      assign joinRow = strobes.allocEn &&
                       ((s0Out && dispSrc0 == PregW'(p)) || (s1Out && dispSrc1 == PregW'(p)));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)      depQ[p] <= '0;
        else if (flush) depQ[p] <= '0;
        else depQ[p] <= (depQ[p] & ~allocOH & {NumEntries{~annNow[p]}}) |
                        (joinRow ? allocOH : '0);
      end
    end

    for (genvar e = 0; e < NumEntries; e++) begin : gDec
      logic [NumPregs-1:0] colHit;
      for (genvar p = 0; p < NumPregs; p++) begin : gCol
        assign colHit[p] = annNow[p] & depQ[p][e];
      end
      assign status.decCnt[e] = CntW'($countones(colHit));

      assert_dec_bounded_R4: assert property (@(posedge clk) disable iff (!rstN)
        $countones(colHit) <= 2);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobes.allocEn) begin
      tagQ[strobes.allocIdx]   <= dispTag;
      dstQ[strobes.allocIdx]   <= dispDst;
      delayQ[strobes.allocIdx] <= dispDelay;
      clsQ[strobes.allocIdx]   <= dispClass;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dstVQ <= '0;
    else if (strobes.allocEn) dstVQ[strobes.allocIdx] <= dispDstValid;
  end

  // Ready queues, one per class
  generate
    for (genvar c = 0; c < NumClasses; c++) begin : gQueue
      logic [NumEntries-1:0] pushMask;
      for (genvar e = 0; e < NumEntries; e++) begin : gSel
        logic [ClsW-1:0] entCls;
        assign entCls = (strobes.allocEn && strobes.allocIdx == IdxW'(e)) ? dispClass : clsQ[e];
        assign pushMask[e] = strobes.readyMask[e] && (entCls == ClsW'(c));
      end
      wk_ready_fifo #(.Slots(NumEntries), .Sources(NumEntries), .IdxW(IdxW)) uQueue (
        .clk(clk), .rstN(rstN), .flush(flush),
        .pushMask(pushMask), .pop(popEn[c]),
        .valid(fifoValid[c]), .head(headIdx[c])
      );
    end
  endgenerate

  generate
    for (genvar p = 0; p < NumPregs; p++) begin : gBusyChk
      assert_ann_clears_busy_R3: assert property (@(posedge clk) disable iff (!rstN || flush)
        (annNow[p] && !(strobes.allocEn && dispDstValid && dispDst == PregW'(p)))
        |=> !busyQ[p]);
    end
  endgenerate
endmodule

// File: rtl/wk_control.sv
module wk_control
  import wk_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         flush,
  input  logic         dispValid,
  output logic         dispReady,
  input  dpStatus_t    status,
  output ctrlStrobes_t strobes
);
  logic [NumEntries-1:0] validQ;
  logic [CntW-1:0] cntQ [NumEntries];
  logic [IdxW-1:0] allocIdx;
  logic allocEn;

  always_comb begin
    allocIdx = '0;
    for (int e = NumEntries - 1; e >= 0; e--)
      if (!validQ[e]) allocIdx = IdxW'(e);
  end

  assign dispReady = ~&validQ;
  assign allocEn   = dispValid & dispReady & ~flush;

  assign strobes.allocEn  = allocEn;
  assign strobes.allocIdx = allocIdx;

  generate
    for (genvar e = 0; e < NumEntries; e++) begin : gEnt
      logic hitZero, direct, isAlloc;
      assign isAlloc = allocEn && (allocIdx == IdxW'(e));
      assign hitZero = validQ[e] && (cntQ[e] != '0) && (status.decCnt[e] != '0) &&
                       (status.decCnt[e] == cntQ[e]);
      assign direct  = isAlloc && (status.srcCnt == '0);
      assign strobes.readyMask[e] = ~flush & (hitZero | direct);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          validQ[e] <= 1'b0;
          cntQ[e]   <= '0;
        end else if (flush) begin
          validQ[e] <= 1'b0;
          cntQ[e]   <= '0;
        end else if (isAlloc) begin
          validQ[e] <= 1'b1;
          cntQ[e]   <= status.srcCnt;
        end else begin
          if (status.issuedMask[e]) validQ[e] <= 1'b0;
          if (validQ[e] && status.decCnt[e] != '0) cntQ[e] <= cntQ[e] - status.decCnt[e];
        end
      end

      assert_issue_when_ready_R3: assert property (@(posedge clk) disable iff (!rstN)
        status.issuedMask[e] |-> (validQ[e] && cntQ[e] == '0));

      assert_free_on_issue_R9: assert property (@(posedge clk) disable iff (!rstN)
        status.issuedMask[e] |=> !validQ[e]);

      assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rstN)
        (validQ[e] && status.decCnt[e] != '0) |-> status.decCnt[e] <= cntQ[e]);
    end
  endgenerate

  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> validQ == '0);
endmodule

// File: rtl/dep_wakeup_sched.sv
module dep_wakeup_sched
  import wk_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       flush,
  input  logic                       dispValid,
  output logic                       dispReady,
  input  logic [TagW-1:0]            dispTag,
  input  logic                       dispSrc0Valid,
  input  logic [PregW-1:0]           dispSrc0,
  input  logic                       dispSrc1Valid,
  input  logic [PregW-1:0]           dispSrc1,
  input  logic                       dispDstValid,
  input  logic [PregW-1:0]           dispDst,
  input  logic [DelayW-1:0]          dispDelay,
  input  logic [ClsW-1:0]            dispClass,
  input  logic [NumClasses-1:0]      issueReq,
  output logic [NumClasses-1:0]      issueValid,
  output logic [NumClasses*IdxW-1:0] issueEntry,
  output logic [NumClasses*TagW-1:0] issueTag
);
  ctrlStrobes_t strobes;
  dpStatus_t    status;

  wk_control uCtrl (
    .clk(clk), .rstN(rstN), .flush(flush),
    .dispValid(dispValid), .dispReady(dispReady),
    .status(status), .strobes(strobes)
  );

  wk_datapath uData (
    .clk(clk), .rstN(rstN), .flush(flush),
    .dispTag(dispTag),
    .dispSrc0Valid(dispSrc0Valid), .dispSrc0(dispSrc0),
    .dispSrc1Valid(dispSrc1Valid), .dispSrc1(dispSrc1),
    .dispDstValid(dispDstValid), .dispDst(dispDst),
    .dispDelay(dispDelay), .dispClass(dispClass),
    .issueReq(issueReq), .strobes(strobes), .status(status),
    .issueValid(issueValid), .issueEntry(issueEntry), .issueTag(issueTag)
  );
endmodule

// File: tb/dep_wakeup_sched_test.sv
module dep_wakeup_sched_test;
  localparam int ClkPeriod = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0;
  logic dispValid = 1'b0;
  logic dispReady;
  logic [7:0] dispTag = '0;
  logic dispSrc0Valid = 1'b0, dispSrc1Valid = 1'b0, dispDstValid = 1'b0;
  logic [5:0] dispSrc0 = '0, dispSrc1 = '0, dispDst = '0;
  logic [1:0] dispDelay = '0;
  logic dispClass = 1'b0;
  logic [1:0] issueReq = '0;
  logic [1:0] issueValid;
  logic [7:0] issueEntry;
  logic [15:0] issueTag;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(ClkPeriod/2) clk = ~clk;

  dep_wakeup_sched uut (
    .clk(clk), .rstN(rstN), .flush(flush),
    .dispValid(dispValid), .dispReady(dispReady), .dispTag(dispTag),
    .dispSrc0Valid(dispSrc0Valid), .dispSrc0(dispSrc0),
    .dispSrc1Valid(dispSrc1Valid), .dispSrc1(dispSrc1),
    .dispDstValid(dispDstValid), .dispDst(dispDst),
    .dispDelay(dispDelay), .dispClass(dispClass),
    .issueReq(issueReq), .issueValid(issueValid),
    .issueEntry(issueEntry), .issueTag(issueTag)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int tagOf(int c);
    return int'(issueTag[c*8 +: 8]);
  endfunction

  function automatic int entOf(int c);
    return int'(issueEntry[c*4 +: 4]);
  endfunction

  task automatic disp(int tag, bit s0v, int s0, bit s1v, int s1,
                      bit dv, int d, int dly, int cls);
    dispValid = 1'b1; dispTag = 8'(tag);
    dispSrc0Valid = s0v; dispSrc0 = 6'(s0);
    dispSrc1Valid = s1v; dispSrc1 = 6'(s1);
    dispDstValid = dv; dispDst = 6'(d);
    dispDelay = 2'(dly); dispClass = cls[0];
    tick();
    dispValid = 1'b0; dispSrc0Valid = 1'b0; dispSrc1Valid = 1'b0; dispDstValid = 1'b0;
  endtask

  task automatic accept(int c);
    issueReq[c] = 1'b1;
    tick();
    issueReq[c] = 1'b0;
  endtask

  task automatic expectHead(string req, int c, int tag);
    chk(req, $sformatf("issueValid[%0d]", c), int'(issueValid[c]), 1);
    chk(req, $sformatf("issueTag[%0d]", c), tagOf(c), tag);
  endtask

  task automatic testReset();
    chk("R1", "dispReady after reset", int'(dispReady), 1);
    chk("R1", "issueValid after reset", int'(issueValid), 0);
  endtask

  task automatic testDirectReady();
    disp(8'h11, 0, 0, 0, 0, 1, 5, 0, 0);
    expectHead("R2", 0, 8'h11);
    chk("R8", "other class idle", int'(issueValid[1]), 0);
    accept(0);
    chk("R2", "queue drained", int'(issueValid), 0);
  endtask

  task automatic testDelayedWake();
    disp(8'h21, 0, 0, 0, 0, 1, 10, 2, 0);
    disp(8'h22, 1, 10, 0, 0, 0, 0, 0, 1);
    chk("R3", "consumer waits before producer issue", int'(issueValid[1]), 0);
    accept(0);
    chk("R3", "consumer waits t+1", int'(issueValid[1]), 0);
    tick();
    chk("R3", "consumer waits t+2", int'(issueValid[1]), 0);
    tick();
    expectHead("R3", 1, 8'h22);
    chk("R8", "class 0 stays empty", int'(issueValid[0]), 0);
    accept(1);
  endtask

  task automatic testBackToBack();
    disp(8'h31, 0, 0, 0, 0, 1, 11, 0, 0);
    disp(8'h32, 1, 11, 0, 0, 0, 0, 0, 0);
    expectHead("R3", 0, 8'h31);
    accept(0);
    expectHead("R3", 0, 8'h32);
    accept(0);
  endtask

  task automatic testTwoSources();
    disp(8'h41, 0, 0, 0, 0, 1, 20, 0, 0);
    disp(8'h42, 0, 0, 0, 0, 1, 21, 0, 1);
    disp(8'h43, 1, 20, 1, 21, 0, 0, 0, 0);
    accept(0);
    chk("R4", "one of two sources announced", int'(issueValid[0]), 0);
    tick();
    chk("R4", "still waiting", int'(issueValid[0]), 0);
    accept(1);
    expectHead("R4", 0, 8'h43);
    accept(0);
  endtask

  task automatic testSameReg();
    disp(8'h51, 0, 0, 0, 0, 1, 30, 0, 1);
    disp(8'h52, 1, 30, 1, 30, 0, 0, 0, 0);
    chk("R5", "waits for shared source", int'(issueValid[0]), 0);
    accept(1);
    expectHead("R5", 0, 8'h52);
    accept(0);
  endtask

  task automatic testSameCycleAnnounce();
    disp(8'h61, 0, 0, 0, 0, 1, 40, 0, 0);
    issueReq[0] = 1'b1;
    disp(8'h62, 1, 40, 0, 0, 0, 0, 0, 1);
    issueReq[0] = 1'b0;
    expectHead("R6", 1, 8'h62);
    accept(1);
  endtask

  task automatic testOrdering();
    disp(8'h71, 0, 0, 0, 0, 1, 50, 0, 1);  // slot 0
    disp(8'h70, 0, 0, 0, 0, 0, 0, 0, 0);   // slot 1
    disp(8'h72, 1, 50, 0, 0, 0, 0, 0, 0);  // slot 2
    accept(0);                              // frees slot 1
    disp(8'h73, 1, 50, 0, 0, 0, 0, 0, 0);  // reuses slot 1
    chk("R7", "both consumers wait", int'(issueValid[0]), 0);
    accept(1);
    expectHead("R7", 0, 8'h73);
    chk("R7", "lower slot first", entOf(0), 1);
    accept(0);
    expectHead("R7", 0, 8'h72);
    chk("R7", "higher slot second", entOf(0), 2);
    accept(0);
  endtask

  task automatic testFull();
    for (int i = 0; i < 16; i++) begin
      chk("R9", $sformatf("dispReady before fill %0d", i), int'(dispReady), 1);
      disp(8'h80 + i, 0, 0, 0, 0, 0, 0, 0, 0);
    end
    chk("R9", "dispReady when full", int'(dispReady), 0);
    disp(8'hFF, 0, 0, 0, 0, 0, 0, 0, 0);
    expectHead("R9", 0, 8'h80);
    accept(0);
    chk("R9", "dispReady after one issue", int'(dispReady), 1);
    for (int i = 1; i < 16; i++) begin
      expectHead("R9", 0, 8'h80 + i);
      accept(0);
    end
    chk("R9", "ignored dispatch never queued", int'(issueValid[0]), 0);
  endtask

  task automatic testFlush();
    disp(8'h91, 0, 0, 0, 0, 1, 60, 3, 0);
    disp(8'h92, 1, 60, 0, 0, 0, 0, 0, 1);
    disp(8'h94, 0, 0, 0, 0, 0, 0, 0, 0);
    accept(0);
    flush = 1'b1;
    tick();
    flush = 1'b0;
    chk("R1", "dispReady after flush", int'(dispReady), 1);
    chk("R10", "queues empty after flush", int'(issueValid), 0);
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R10", $sformatf("flushed consumer stays gone %0d", i), int'(issueValid), 0);
    end
    disp(8'h93, 1, 60, 0, 0, 0, 0, 0, 1);
    expectHead("R10", 1, 8'h93);
    accept(1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    tick();
    tick();
    rstN = 1'b1;
    tick();
    testReset();
    testDirectReady();
    testDelayedWake();
    testBackToBack();
    testTwoSources();
    testSameReg();
    testSameCycleAnnounce();
    testOrdering();
    testFull();
    testFlush();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule